// File: doc/BRIEF.md
# Cartridge Interrupt Counter with Scanline Prescaler

This block raises an interrupt request for a game cartridge's mapper after a programmed number of events. Software loads an 8-bit reload value in two 4-bit halves, then writes a control byte that enables counting and chooses what is counted. In cycle mode every CPU cycle is one event. In line mode a prescaler converts CPU cycles into display lines. The prescaler starts at 341 video dots and takes 3 dots away on every CPU cycle. Each time it reaches zero or less it gains 341 dots back and produces one event. A line therefore lasts 114, 114 and then 113 CPU cycles, and that pattern repeats.

The event counter counts upward. When it steps past its top value it reloads from the reload value and raises the request. The request stays high until software writes the control register or the acknowledge register. An acknowledge write can also re-arm counting: it copies a saved "enable after acknowledge" bit into the live enable. Address decoding and bank mapping are done elsewhere. This block takes one write strobe per register and a CPU-cycle enable.

Top module: `irq_cycle_counter`

## Requirements
- R1: After reset the request output is low and the reload value, counter, control bits and prescaler are all zero. If counting is then enabled through an acknowledge without a reload, the request rises after exactly 256 counted cycles in cycle mode.
- R2: A low-half write stores wr_data[3:0] into reload bits 3:0. A high-half write stores wr_data[3:0] into reload bits 7:4. Bits 7:4 of wr_data are ignored by both writes.
- R3: A control write stores wr_data[2:0] as follows: bit 0 is enable-after-acknowledge, bit 1 is enable and bit 2 is cycle mode (1 = cycle mode, 0 = line mode). When wr_data[1] is 1, the write also loads the counter from the reload value and sets the prescaler to 341.
- R4: Every control write clears a pending request on the following cycle.
- R5: An acknowledge write clears the pending request and copies control bit 0 into control bit 1. Control bits 0 and 2 do not change.
- R6: When enabled in cycle mode, the counter advances once on each cycle in which cpu_ce is high.
- R7: When enabled in line mode, each cpu_ce cycle subtracts 3 from the prescaler. When the result is zero or negative, 341 is added back and the counter advances once. From a reload, the counter advances after 114, 228 and 341 cycles, and this pattern repeats.
- R8: Each advance adds one to the counter. An advance from 0xFF instead loads the reload value and sets the request. The request stays set until a control or acknowledge write.
- R9: While the enable bit is clear, neither the prescaler nor the counter changes. After a later re-enable without a reload, counting resumes from the held values.
- R10: No counting happens in a cycle with cpu_ce low or in a cycle with a control or acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ce | input | 1 | High for one clock per CPU cycle |
| wr_lat_lo | input | 1 | Write strobe for reload bits 3:0 |
| wr_lat_hi | input | 1 | Write strobe for reload bits 7:4 |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_ack | input | 1 | Write strobe for the acknowledge register |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 10-bit signed prescaler, 341 dots per line, 3 dots per cycle and the line prescaler present. With these values a full 256-step wrap starting from the reset count can be reached within a few hundred cycles. So can a reload-to-request span of exactly three lines, which covers every part of the 114/114/113 line pattern. The random phase mixes gaps in cpu_ce, writes in both modes and acknowledges that re-arm or disarm counting, and compares the request line with a bench model on every cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   // Field order matches the control byte encoding: [2] mode, [1] enable, [0] ack-enable
   typedef struct packed {
      logic cyc_mode;
      logic enable;
      logic ack_en;
   } irqc_ctrl_t;
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int NIB_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lat_lo,
   input  logic              wr_lat_hi,
   input  logic              wr_ctrl,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  lat_q,
   output irqc_ctrl_t        ctrl_q,
   output logic              reload
);
   assign reload = wr_ctrl & wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else begin
         if (wr_lat_lo) lat_q[NIB_W-1:0]     <= wr_data[NIB_W-1:0];
         if (wr_lat_hi) lat_q[CNT_W-1:NIB_W] <= wr_data[NIB_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= irqc_ctrl_t'(wr_data[2:0]);
      end else if (wr_ack) begin
         ctrl_q.enable <= ctrl_q.ack_en;
      end
   end
endmodule

// File: rtl/irqc_prescale.sv
`timescale 1ns/1ps
module irqc_prescale #(
   parameter int PRE_W        = 10,
   parameter int LINE_DOTS    = 341,
   parameter int DOTS_PER_CYC = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    reload,
   output logic                    tick,
   output logic signed [PRE_W-1:0] pre_q
);
   localparam logic signed [PRE_W-1:0] LINE_S = PRE_W'(LINE_DOTS);
   localparam logic signed [PRE_W-1:0] DOTS_S = PRE_W'(DOTS_PER_CYC);

   logic signed [PRE_W-1:0] nxt;
   logic                    spent;

   assign nxt   = pre_q - DOTS_S;
   assign spent = nxt[PRE_W-1] || (nxt == '0);
   assign tick  = step & spent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (reload) begin
         pre_q <= LINE_S;
      end else if (step) begin
         pre_q <= spent ? (nxt + LINE_S) : nxt;
      end
   end
endmodule

// File: rtl/irqc_count.sv
`timescale 1ns/1ps
module irqc_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic             clr,
   input  logic [CNT_W-1:0] lat_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq
);
   logic at_top;
   assign at_top = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (reload) begin
         cnt_q <= lat_q;
      end else if (tick) begin
         cnt_q <= at_top ? lat_q : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (clr) begin
         irq <= 1'b0;
      end else if (tick && at_top) begin
         irq <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_cycle_counter.sv
`timescale 1ns/1ps
module irq_cycle_counter
   import irqc_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int NIB_W        = 4,
   parameter int DATA_W       = 8,
   parameter int PRE_W        = 10,
   parameter int LINE_DOTS    = 341,
   parameter int DOTS_PER_CYC = 3,
   parameter bit SCANLINE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ce,
   input  logic              wr_lat_lo,
   input  logic              wr_lat_hi,
   input  logic              wr_ctrl,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq
);
   localparam int PRE_MAX = (1 << (PRE_W - 1)) - 1;

   if (CNT_W != 2 * NIB_W) begin : g_bad_cnt
      $error("CNT_W must be twice NIB_W");
   end
   if (DATA_W < 3 || DATA_W < NIB_W) begin : g_bad_data
      $error("DATA_W too narrow for control or reload halves");
   end
   if (LINE_DOTS > PRE_MAX || DOTS_PER_CYC < 1 || DOTS_PER_CYC >= LINE_DOTS) begin : g_bad_pre
      $error("prescaler range does not fit PRE_W");
   end

   irqc_ctrl_t              ctrl_q;
   logic [CNT_W-1:0]        lat_q;
   logic [CNT_W-1:0]        cnt_q;
   logic signed [PRE_W-1:0] pre_q;
   logic                    reload;
   logic                    busy;
   logic                    step;
   logic                    cyc_tick;
   logic                    line_tick;
   logic                    tick;
   logic                    ctrl_en;

   assign ctrl_en  = ctrl_q.enable;
   assign busy     = wr_ctrl | wr_ack;
   assign step     = cpu_ce & ctrl_q.enable & ~busy;
   assign cyc_tick = step & ctrl_q.cyc_mode;
   assign tick     = cyc_tick | line_tick;

   irqc_regs #(.CNT_W(CNT_W), .NIB_W(NIB_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lat_lo (wr_lat_lo),
      .wr_lat_hi (wr_lat_hi),
      .wr_ctrl   (wr_ctrl),
      .wr_ack    (wr_ack),
      .wr_data   (wr_data),
      .lat_q     (lat_q),
      .ctrl_q    (ctrl_q),
      .reload    (reload)
   );

   if (SCANLINE_EN) begin : g_line
      irqc_prescale #(
         .PRE_W(PRE_W), .LINE_DOTS(LINE_DOTS), .DOTS_PER_CYC(DOTS_PER_CYC)
      ) u_pre (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (step & ~ctrl_q.cyc_mode),
         .reload (reload),
         .tick   (line_tick),
         .pre_q  (pre_q)
      );
   end else begin : g_noline
      assign line_tick = 1'b0;
      assign pre_q     = '0;
   end

   irqc_count #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .reload (reload),
      .clr    (busy),
      .lat_q  (lat_q),
      .cnt_q  (cnt_q),
      .irq    (irq)
   );
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
   parameter int CNT_W     = 8,
   parameter int PRE_W     = 10,
   parameter int LINE_DOTS = 341
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cpu_ce,
   input logic                    wr_ctrl,
   input logic                    wr_ack,
   input logic                    irq,
   input logic                    ctrl_en,
   input logic [CNT_W-1:0]        cnt_q,
   input logic signed [PRE_W-1:0] pre_q
);
   AST_CTRL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !irq); // R4

   AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !irq); // R5

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_ctrl && !wr_ack) |=> irq); // R8

   AST_NO_RISE_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ce |=> !$rose(irq)); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !wr_ctrl && !wr_ack) |=> ($stable(cnt_q) && $stable(pre_q))); // R9

   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q >= 0) && (pre_q <= PRE_W'(LINE_DOTS))); // R7
endmodule

bind irq_cycle_counter irqc_checker #(
   .CNT_W(CNT_W), .PRE_W(PRE_W), .LINE_DOTS(LINE_DOTS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_ce  (cpu_ce),
   .wr_ctrl (wr_ctrl),
   .wr_ack  (wr_ack),
   .irq     (irq),
   .ctrl_en (ctrl_en),
   .cnt_q   (cnt_q),
   .pre_q   (pre_q)
);

// File: tb/tb_irq_cycle_counter.sv
`timescale 1ns/1ps
module tb_irq_cycle_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_ce = 1'b0;
   logic       wr_lat_lo = 1'b0, wr_lat_hi = 1'b0, wr_ctrl = 1'b0, wr_ack = 1'b0;
   logic [7:0] wr_data = '0;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   irq_cycle_counter dut (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce),
      .wr_lat_lo(wr_lat_lo), .wr_lat_hi(wr_lat_hi),
      .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wr_data(wr_data), .irq(irq)
   );

   // Bench model built from the requirements
   logic [7:0] m_lat;
   logic [2:0] m_ctrl;
   int         m_pre;
   int         m_cnt;
   logic       m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lat = '0; m_ctrl = '0; m_pre = 0; m_cnt = 0; m_irq = 1'b0;
      end else begin
         logic tk;
         tk = 1'b0;
         if (!(wr_ctrl || wr_ack) && cpu_ce && m_ctrl[1]) begin   // R10
            if (m_ctrl[2]) tk = 1'b1;                              // R6
            else begin
               m_pre = m_pre - 3;                                  // R7
               if (m_pre <= 0) begin m_pre = m_pre + 341; tk = 1'b1; end
            end
         end
         if (tk) begin
            if (m_cnt == 255) begin m_cnt = m_lat; m_irq = 1'b1; end   // R8
            else m_cnt = m_cnt + 1;
         end
         if (wr_ctrl) begin
            m_ctrl = wr_data[2:0]; m_irq = 1'b0;
            if (wr_data[1]) begin m_cnt = m_lat; m_pre = 341; end
         end
         if (wr_ack) begin m_irq = 1'b0; m_ctrl[1] = m_ctrl[0]; end
         if (wr_lat_lo) m_lat[3:0] = wr_data[3:0];                 // R2
         if (wr_lat_hi) m_lat[7:4] = wr_data[3:0];
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input logic ce, input int kind, input logic [7:0] d);
      cpu_ce = ce; wr_data = d;
      wr_lat_lo = (kind == 1); wr_lat_hi = (kind == 2);
      wr_ctrl   = (kind == 3); wr_ack    = (kind == 4);
      @(posedge clk); @(negedge clk);
      wr_lat_lo = 0; wr_lat_hi = 0; wr_ctrl = 0; wr_ack = 0; cpu_ce = 0;
      chk(tag, int'(irq), int'(m_irq));
   endtask

   task automatic run_until_irq(input string tag, input int max, output int n);
      n = 0;
      while (irq == 1'b0 && n < max) begin
         cyc(tag, 1'b1, 0, 8'h00);
         n++;
      end
   endtask

   initial begin
      int n;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(irq), 0);

      // R1: arm via acknowledge without reload; counter starts from zero
      cyc("R1", 1'b1, 3, 8'h05);
      cyc("R1", 1'b1, 4, 8'h00);
      run_until_irq("R1", 400, n);
      chk("R1", n, 256);

      // R2/R3/R4: reload 0xF0 (upper data bits ignored), cycle mode reload
      cyc("R2", 1'b1, 1, 8'hA0);
      cyc("R2", 1'b1, 2, 8'h5F);
      cyc("R4", 1'b1, 3, 8'h06);
      chk("R4", int'(irq), 0);
      run_until_irq("R3", 400, n);
      chk("R2", n, 16);

      // R8: request sticks across further wraps
      repeat (40) cyc("R8", 1'b1, 0, 8'h00);
      chk("R8", int'(irq), 1);

      // R5: ack with ack-enable clear disables counting, mode kept
      cyc("R5", 1'b1, 4, 8'h00);
      chk("R5", int'(irq), 0);
      repeat (300) cyc("R9", 1'b1, 0, 8'h00);
      chk("R9", int'(irq), 0);

      // R7: line mode, reload 0xFD -> three lines = 341 cycles
      cyc("R7", 1'b1, 1, 8'h0D);
      cyc("R7", 1'b1, 2, 8'h0F);
      cyc("R7", 1'b1, 3, 8'h02);
      run_until_irq("R7", 600, n);
      chk("R7", n, 341);

      // R10: cpu_ce low and writes stall counting; R9 resume from held value
      cyc("R10", 1'b1, 1, 8'h0E);
      cyc("R10", 1'b1, 2, 8'h0F);
      cyc("R10", 1'b1, 3, 8'h07);          // 0xFE, cycle mode, ack-enable set
      repeat (50) cyc("R10", 1'b0, 0, 8'h00);
      cyc("R10", 1'b1, 0, 8'h00);          // count 0xFF
      cyc("R9", 1'b1, 3, 8'h05);           // disable, no reload
      repeat (20) cyc("R9", 1'b1, 0, 8'h00);
      cyc("R9", 1'b1, 4, 8'h00);           // re-enable via ack
      chk("R9", int'(irq), 0);
      cyc("R6", 1'b1, 0, 8'h00);           // 0xFF -> wrap
      chk("R6", int'(irq), 1);

      // Random phase against the model
      for (int i = 0; i < 6000; i++) begin
         int r;
         int k;
         r = $urandom_range(0, 99);
         k = (r < 4) ? 1 : (r < 8) ? 2 : (r < 11) ? 3 : (r < 15) ? 4 : 0;
         cyc("R8", ($urandom_range(0, 3) != 0), k, 8'($urandom_range(0, 255)));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule